// File: doc/BRIEF.md
# Segment Table Translation Unit

This block turns a logical address, given as a segment index plus an offset inside that segment, into a physical address. It works on one request at a time. First it compares the segment index against the table length register. If the index is in range, it reads that segment's descriptor from memory, at the table base register plus eight bytes per index, as two 32-bit words. It then tests the offset against the descriptor's limit and the requested access kind against the descriptor's permission bits. When every test passes, it returns the descriptor base plus the offset.

A load/store or fetch front end sends a request with a valid/ready handshake. It receives a response with a physical address and a 2-bit fault code, also under a valid/ready handshake. The table base and length registers are plain inputs. The unit captures them when it accepts a request. Descriptor reads go out on a simple read port: the request address is held until it is accepted, and the data returns some cycles later with a valid strobe.

Top module: `segxlat_top`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: A segment index greater than or equal to the captured table length gives fault code 01 with physical address 0, and no descriptor read is issued.
- R3: For an in-range index s, exactly two reads are issued. The first is at table base + 8*s and returns the base word. The second is at table base + 8*s + 4 and returns the attribute word.
- R4: In the attribute word, bit 0 permits read, bit 1 permits write, bit 2 permits execute, and bits [8 +: OFF_W] (bits 23:8 by default) hold the segment limit. All other attribute bits are ignored.
- R5: An offset greater than or equal to the limit gives fault code 10 with physical address 0. This happens whatever the permission bits say, because the limit test is made before the permission test.
- R6: Access codes are 00 read, 01 write, 10 execute and 11 reserved. An access whose permission bit is clear, and every reserved access, gives fault code 11 with physical address 0.
- R7: A request that passes all tests gives fault code 00 and physical address = base word + offset, taken modulo 2^32.
- R8: `req_ready` stays low from the accepting edge until the response has been taken. `rsp_valid`, `rsp_fault` and `rsp_paddr` hold steady while `rsp_ready` is low.
- R9: `mem_req_valid` and `mem_addr` hold steady while `mem_req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_base | input | 32 | Byte address of descriptor 0 |
| tbl_len | input | SEG_W+1 | Number of valid segments |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_seg | input | SEG_W | Segment index |
| req_off | input | OFF_W | Offset within the segment |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 reserved |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_addr | output | 32 | Byte address of the descriptor word |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rdata | input | 32 | Read data word |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 32 | Physical address, 0 on any fault |
| rsp_fault | output | 2 | 00 none, 01 segment range, 10 limit, 11 permission |

## Verification
The hardest cases to reach from the ports are descriptors that would fail more than one test at once, together with memory backpressure that lands in different phases of the two-word fetch. For the first, the bench stores descriptors with a zero limit and no permissions, and with stray bits set in the ignored attribute fields. It then checks that only the first failing test is reported. For the second, the model memory drops its ready on a free-running pattern that is independent of the request timing, so stalls fall on the first word, the second word, or neither. The bench watches the read port across those stalls and also holds the response consumer off for several cycles.

// File: rtl/segxlat_pkg.sv
package segxlat_pkg;

    localparam int WORD_W      = 32;
    localparam int ENTRY_BYTES = 8;
    localparam int ENTRY_SH    = $clog2(ENTRY_BYTES);
    localparam int WORD_BYTES  = WORD_W / 8;
    localparam int LIM_LSB     = 8;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'b00,
        FLT_SEG   = 2'b01,
        FLT_LIMIT = 2'b10,
        FLT_PERM  = 2'b11
    } fault_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    function automatic perm_t perm_of(input logic [WORD_W-1:0] attr);
        return perm_t'(attr[2:0]);
    endfunction

    function automatic logic perm_ok(input perm_t p, input acc_e a);
        case (a)
            ACC_READ:  return p.r;
            ACC_WRITE: return p.w;
            ACC_EXEC:  return p.x;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/segxlat_fetch.sv
module segxlat_fetch
    import segxlat_pkg::*;
#(
    parameter int SEG_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SEG_W-1:0]  idx,
    input  logic [WORD_W-1:0] tbase,
    output logic              done,
    output logic [WORD_W-1:0] ent_base,
    output logic [WORD_W-1:0] ent_attr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [WORD_W-1:0] mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rdata
);

    typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT, F_DONE} fetch_st_e;

    fetch_st_e         st_q;
    logic              second_q;
    logic [WORD_W-1:0] addr_q;
    logic [WORD_W-1:0] base_q;
    logic [WORD_W-1:0] attr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= F_IDLE;
            second_q <= 1'b0;
            addr_q   <= '0;
            base_q   <= '0;
            attr_q   <= '0;
        end else begin
            case (st_q)
                F_IDLE: begin
                    if (start) begin
                        addr_q   <= tbase + (WORD_W'(idx) << ENTRY_SH);
                        second_q <= 1'b0;
                        st_q     <= F_REQ;
                    end
                end
                F_REQ: begin
                    if (mem_req_ready) st_q <= F_WAIT;
                end
                F_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!second_q) begin
                            base_q   <= mem_rdata;
                            second_q <= 1'b1;
                            addr_q   <= addr_q + WORD_W'(WORD_BYTES);
                            st_q     <= F_REQ;
                        end else begin
                            attr_q <= mem_rdata;
                            st_q   <= F_DONE;
                        end
                    end
                end
                default: st_q <= F_IDLE;
            endcase
        end
    end

    assign done          = (st_q == F_DONE);
    assign mem_req_valid = (st_q == F_REQ);
    assign mem_addr      = addr_q;
    assign ent_base      = base_q;
    assign ent_attr      = attr_q;

    // R9: read request held until accepted
    assert_memreq_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));

endmodule

// File: rtl/segxlat_check.sv
module segxlat_check
    import segxlat_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  logic [OFF_W-1:0]  off,
    input  acc_e              acc,
    input  logic [WORD_W-1:0] ent_base,
    input  logic [WORD_W-1:0] ent_attr,
    output fault_e            fault,
    output logic [WORD_W-1:0] paddr
);

    logic [OFF_W-1:0] lim;
    perm_t            perm;

    assign lim  = ent_attr[LIM_LSB +: OFF_W];
    assign perm = perm_of(ent_attr);

    always_comb begin
        if (off >= lim) begin
            fault = FLT_LIMIT;
        end else if (!perm_ok(perm, acc)) begin
            fault = FLT_PERM;
        end else begin
            fault = FLT_NONE;
        end
        paddr = (fault == FLT_NONE) ? (ent_base + WORD_W'(off)) : '0;
    end

endmodule

// File: rtl/segxlat_top.sv
module segxlat_top
    import segxlat_pkg::*;
#(
    parameter int SEG_W = 4,
    parameter int OFF_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       tbl_base,
    input  logic [SEG_W:0]    tbl_len,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_acc,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [31:0]       mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [31:0]       rsp_paddr,
    output logic [1:0]        rsp_fault
);

    typedef enum logic [1:0] {T_IDLE, T_BOUND, T_FETCH, T_RESP} top_st_e;

    top_st_e           st_q;
    logic [SEG_W-1:0]  seg_q;
    logic [OFF_W-1:0]  off_q;
    acc_e              acc_q;
    logic [WORD_W-1:0] tbase_q;
    logic [SEG_W:0]    len_q;
    fault_e            fault_q;
    logic [WORD_W-1:0] paddr_q;

    logic              in_range;
    logic              f_start;
    logic              f_done;
    logic [WORD_W-1:0] ent_base;
    logic [WORD_W-1:0] ent_attr;
    fault_e            chk_fault;
    logic [WORD_W-1:0] chk_paddr;

    assign in_range = ({1'b0, seg_q} < len_q);
    assign f_start  = (st_q == T_BOUND) && in_range;

    segxlat_fetch #(.SEG_W(SEG_W)) fetch_i (
        .clk           (clk),
        .rst           (rst),
        .start         (f_start),
        .idx           (seg_q),
        .tbase         (tbase_q),
        .done          (f_done),
        .ent_base      (ent_base),
        .ent_attr      (ent_attr),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_addr      (mem_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rdata     (mem_rdata)
    );

    segxlat_check #(.OFF_W(OFF_W)) check_i (
        .off      (off_q),
        .acc      (acc_q),
        .ent_base (ent_base),
        .ent_attr (ent_attr),
        .fault    (chk_fault),
        .paddr    (chk_paddr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= T_IDLE;
            seg_q   <= '0;
            off_q   <= '0;
            acc_q   <= ACC_READ;
            tbase_q <= '0;
            len_q   <= '0;
            fault_q <= FLT_NONE;
            paddr_q <= '0;
        end else begin
            case (st_q)
                T_IDLE: begin
                    if (req_valid) begin
                        seg_q   <= req_seg;
                        off_q   <= req_off;
                        acc_q   <= acc_e'(req_acc);
                        tbase_q <= tbl_base;
                        len_q   <= tbl_len;
                        st_q    <= T_BOUND;
                    end
                end
                T_BOUND: begin
                    if (in_range) begin
                        st_q <= T_FETCH;
                    end else begin
                        fault_q <= FLT_SEG;
                        paddr_q <= '0;
                        st_q    <= T_RESP;
                    end
                end
                T_FETCH: begin
                    if (f_done) begin
                        fault_q <= chk_fault;
                        paddr_q <= chk_paddr;
                        st_q    <= T_RESP;
                    end
                end
                default: begin
                    if (rsp_ready) st_q <= T_IDLE;
                end
            endcase
        end
    end

    assign req_ready = (st_q == T_IDLE);
    assign rsp_valid = (st_q == T_RESP);
    assign rsp_paddr = paddr_q;
    assign rsp_fault = fault_q;

    // R2: no descriptor read for an out-of-range index
    assert_no_oob_fetch_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> ({1'b0, seg_q} < len_q));

    // R5 / R6: a faulted response carries no address
    assert_fault_zero_addr_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_paddr == '0));

    // R8: response held while the consumer stalls
    assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

    // R8: one request in flight
    assert_single_flight_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R2: descriptor reads only while a fetch is pending, never with a response up
    assert_no_read_during_rsp_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !mem_req_valid);

endmodule

// File: tb/segxlat_top_tb_top.sv
`timescale 1ns/1ps
module segxlat_top_tb_top;

    localparam int SEG_W = 4;
    localparam int OFF_W = 16;
    localparam logic [31:0] TBASE = 32'h0000_0100;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [31:0]       tbl_base = TBASE;
    logic [SEG_W:0]    tbl_len = 5'd6;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [SEG_W-1:0]  req_seg = '0;
    logic [OFF_W-1:0]  req_off = '0;
    logic [1:0]        req_acc = 2'b00;
    logic              mem_req_valid;
    logic              mem_req_ready;
    logic [31:0]       mem_addr;
    logic              mem_rsp_valid;
    logic [31:0]       mem_rdata;
    logic              rsp_valid;
    logic              rsp_ready = 1'b0;
    logic [31:0]       rsp_paddr;
    logic [1:0]        rsp_fault;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    segxlat_top #(.SEG_W(SEG_W), .OFF_W(OFF_W)) dut_i (
        .clk(clk), .rst(rst), .tbl_base(tbl_base), .tbl_len(tbl_len),
        .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg),
        .req_off(req_off), .req_acc(req_acc),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    // model memory: stalls on a free-running pattern, answers two cycles after accept
    logic [31:0] mem [256];
    logic [2:0]  tick;
    logic [1:0]  pend_cnt;
    logic [31:0] pend_addr;
    int          rd_total;
    logic [31:0] last_addr;
    logic [31:0] prev_addr;
    int          hold_viol;
    logic        was_stalled;
    logic [31:0] stalled_addr;

    assign mem_req_ready = (tick[1:0] != 2'b00);

    always @(posedge clk) begin
        if (rst) begin
            tick          <= '0;
            pend_cnt      <= '0;
            pend_addr     <= '0;
            mem_rsp_valid <= 1'b0;
            mem_rdata     <= '0;
            rd_total      <= 0;
            last_addr     <= '0;
            prev_addr     <= '0;
            hold_viol     <= 0;
            was_stalled   <= 1'b0;
            stalled_addr  <= '0;
        end else begin
            tick          <= tick + 3'd1;
            mem_rsp_valid <= 1'b0;
            if (pend_cnt == 2'd1) begin
                mem_rsp_valid <= 1'b1;
                mem_rdata     <= mem[pend_addr[9:2]];
                pend_cnt      <= 2'd0;
            end else if (pend_cnt > 2'd1) begin
                pend_cnt <= pend_cnt - 2'd1;
            end
            if (mem_req_valid && mem_req_ready) begin
                pend_addr <= mem_addr;
                pend_cnt  <= 2'd2;
                rd_total  <= rd_total + 1;
                prev_addr <= last_addr;
                last_addr <= mem_addr;
            end
            if (was_stalled && (!mem_req_valid || mem_addr != stalled_addr))
                hold_viol <= hold_viol + 1;
            was_stalled  <= mem_req_valid && !mem_req_ready;
            stalled_addr <= mem_addr;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put_entry(input int s, input logic [31:0] base, input logic [31:0] attr);
        mem[(TBASE >> 2) + 2 * s]     = base;
        mem[(TBASE >> 2) + 2 * s + 1] = attr;
    endtask

    function automatic logic [31:0] attr_word(input logic [15:0] lim, input logic [2:0] xwr);
        return (32'(lim) << 8) | 32'(xwr);
    endfunction

    // one translation; checks fault, address, read traffic and handshake
    task automatic xlat(input int s, input logic [15:0] off, input logic [1:0] acc,
                        input logic [1:0] exp_f, input logic [31:0] exp_pa,
                        input int stall, input string tag);
        int rd0;
        int n;
        logic [31:0] pa;
        logic [1:0]  f;
        @(negedge clk);
        req_seg   = SEG_W'(s);
        req_off   = off;
        req_acc   = acc;
        req_valid = 1'b1;
        n = 0;
        while (!req_ready && n < 100) begin @(negedge clk); n++; end
        rd0 = rd_total;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, {tag, " R8 busy after accept"}, 32'(req_ready), 32'd0);
        n = 0;
        while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
        pa = rsp_paddr;
        f  = rsp_fault;
        check(rsp_valid == 1'b1, {tag, " response arrives"}, 32'(rsp_valid), 32'd1);
        check(f == exp_f, {tag, " fault code"}, 32'(f), 32'(exp_f));
        check(pa == exp_pa, {tag, " physical address"}, pa, exp_pa);
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            check(rsp_valid && rsp_paddr == pa && rsp_fault == f && !req_ready,
                  {tag, " R8 response held"}, rsp_paddr, pa);
        end
        if (exp_f == 2'b01) begin
            check(rd_total == rd0, {tag, " R2 no descriptor read"}, 32'(rd_total - rd0), 32'd0);
        end else begin
            check(rd_total - rd0 == 2, {tag, " R3 two reads"}, 32'(rd_total - rd0), 32'd2);
            check(prev_addr == TBASE + 32'(8 * s), {tag, " R3 base word address"},
                  prev_addr, TBASE + 32'(8 * s));
            check(last_addr == TBASE + 32'(8 * s + 4), {tag, " R3 attribute word address"},
                  last_addr, TBASE + 32'(8 * s + 4));
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check(req_ready && !rsp_valid, {tag, " R8 idle after take"}, 32'(req_ready), 32'd1);
    endtask

    task automatic t_reset;
        check(req_ready == 1'b1, "R1 req_ready after reset", 32'(req_ready), 32'd1);
        check(rsp_valid == 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check(mem_req_valid == 1'b0, "R1 mem_req_valid after reset", 32'(mem_req_valid), 32'd0);
    endtask

    task automatic t_legal;
        xlat(0, 16'h0040, 2'b00, 2'b00, 32'h0001_0040, 0, "R7 read in seg0");
        xlat(1, 16'h0123, 2'b10, 2'b00, 32'h0020_0123, 3, "R7 execute in seg1");
        xlat(0, 16'h00FF, 2'b00, 2'b00, 32'h0001_00FF, 1, "R7 offset limit-1");
        xlat(3, 16'h0200, 2'b01, 2'b00, 32'h0000_0100, 0, "R7 wrap modulo 2^32");
    endtask

    task automatic t_limit;
        xlat(0, 16'h0100, 2'b00, 2'b10, 32'h0, 2, "R5 offset equals limit");
        xlat(4, 16'h0000, 2'b00, 2'b10, 32'h0, 0, "R5 zero limit");
        xlat(5, 16'h0040, 2'b11, 2'b10, 32'h0, 0, "R5 limit before permission");
    endtask

    task automatic t_perm;
        xlat(0, 16'h0010, 2'b01, 2'b11, 32'h0, 0, "R6 write to read-only");
        xlat(0, 16'h0010, 2'b10, 2'b11, 32'h0, 0, "R6 execute denied");
        xlat(3, 16'h0010, 2'b11, 2'b11, 32'h0, 0, "R6 reserved access");
        xlat(5, 16'h0010, 2'b00, 2'b11, 32'h0, 0, "R6 no permissions");
    endtask

    task automatic t_fields;
        xlat(2, 16'h0010, 2'b01, 2'b00, 32'h0030_0010, 0, "R4 write ok, stray bits ignored");
        xlat(2, 16'h07FF, 2'b00, 2'b00, 32'h0030_07FF, 0, "R4 limit field read");
        xlat(2, 16'h0800, 2'b00, 2'b10, 32'h0, 0, "R4 limit field bound");
        xlat(2, 16'h0010, 2'b10, 2'b11, 32'h0, 0, "R4 execute bit clear");
    endtask

    task automatic t_range;
        xlat(6, 16'h0000, 2'b00, 2'b01, 32'h0, 2, "R2 index equals length");
        xlat(15, 16'h0000, 2'b00, 2'b01, 32'h0, 0, "R2 top index");
        xlat(5, 16'h0050, 2'b00, 2'b10, 32'h0, 0, "R2 last legal index fetched");
        @(negedge clk);
        tbl_len = 5'd0;
        xlat(0, 16'h0000, 2'b00, 2'b01, 32'h0, 0, "R2 empty table");
        @(negedge clk);
        tbl_len = 5'd16;
        xlat(0, 16'h0001, 2'b00, 2'b00, 32'h0001_0001, 0, "R2 full-length table");
        @(negedge clk);
        tbl_len = 5'd6;
    endtask

    task automatic t_memhold;
        for (int k = 0; k < 4; k++)
            xlat(1, 16'(k), 2'b00, 2'b00, 32'h0020_0000 + 32'(k), k, "R9 fetch under stall");
        check(hold_viol == 0, "R9 read request held", 32'(hold_viol), 32'd0);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
        put_entry(0, 32'h0001_0000, attr_word(16'h0100, 3'b001));
        put_entry(1, 32'h0020_0000, attr_word(16'h1000, 3'b101));
        put_entry(2, 32'h0030_0000, 32'hAB00_0000 | attr_word(16'h0800, 3'b011) | 32'h0000_00F8);
        put_entry(3, 32'hFFFF_FF00, attr_word(16'hFFFF, 3'b111));
        put_entry(4, 32'h0000_5000, attr_word(16'h0000, 3'b111));
        put_entry(5, 32'h0000_6000, attr_word(16'h0040, 3'b000));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_legal();
        t_limit();
        t_perm();
        t_fields();
        t_range();
        t_memhold();
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule